// File: doc/BRIEF.md
# Credit-Paced Request Issuer with Retry Parking

This block sits on the requester side of a request channel that is under credit flow control. A client hands it requests through a valid/ready handshake. Each request lands in one of a small set of slots. A request leaves on the request-out port only while the block holds a pool credit, and each such issue spends one credit. The responder answers each issued request, by slot tag, in one of two ways. An accept completes the request and hands the credit back. A retry also comes with the credit taken away.

A retried request is parked and is not sent again on its own. The responder later sends an untagged credit grant. That grant is bound to the oldest parked request that has not yet been granted, and the request is then reissued with its allow-retry bit cleared. The responder is therefore obliged to accept it. Granted reissues go out ahead of new requests and do not touch the pool. A grant that finds no parked request waiting adds one credit to the pool.

The responder can also flag heavy load on any response. While the last response carried that flag, consecutive new issues are spaced by a programmable number of idle cycles. Requests of the prefetch-target opcode are never retryable, even on their first issue. A retry aimed at a request that was sent non-retryable is a protocol violation and sets a sticky error flag.

Top module: `crq_retry_ctrl`

## Requirements
- R1: After reset `in_ready` is 1, `out_valid`, `done_valid` and `proto_err` are 0, and with no responses exactly INIT_CREDITS (default 2) requests are issued.
- R2: A new request is issued only while the pool credit count is non-zero, and each new issue spends one credit. An accept response returns one credit, so one further pending request is issued on the second clock edge after that response.
- R3: On issue, `out_op` and `out_payload` carry the values captured from the client, and `out_tag` is the slot index. The first issue has `out_allow_retry` = 1, except when `out_op` equals PREFETCH_OP (all ones, 4'hF by default), which is issued with 0.
- R4: An accept response (`rsp_kind` = 2'd0) whose tag names a request that awaits its response produces `done_valid` = 1 with `done_tag` equal to that tag on the next edge, and frees the slot.
- R5: A retry response (`rsp_kind` = 2'd1) for a retryable request returns no credit and parks the request, which is not reissued until a grant arrives.
- R6: A grant (`rsp_kind` = 2'd2) that finds a parked, ungranted request makes that request reissue with `out_allow_retry` = 0 on the second edge after the grant. The reissue takes precedence over a pending new request in the same cycle and spends no pool credit.
- R7: A grant that finds no parked, ungranted request adds one credit to the pool.
- R8: Parked requests are reissued in the order they were parked, oldest first.
- R9: If the most recent response carried `rsp_busy` = 1, the next new issue after a new issue comes `busy_gap` + 1 cycles later, leaving `busy_gap` idle cycles. With `rsp_busy` = 0 new issues can go out on consecutive cycles.
- R10: A retry response for a request issued with `out_allow_retry` = 0 sets `proto_err`, which stays at 1 until reset. The request stays outstanding, and a later accept still completes it.
- R11: `in_ready` is 0 whenever every slot is occupied.
- R12: An accept or retry response whose tag names a slot that is not awaiting a response has no effect: no `done_valid` appears and no state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busy_gap | input | GAP_W | Idle cycles between new issues while the responder is busy |
| in_valid | input | 1 | Client request valid |
| in_op | input | OP_W | Client request opcode |
| in_payload | input | PLD_W | Client request payload |
| in_ready | output | 1 | A slot is free to take a request |
| out_valid | output | 1 | Request issued this cycle |
| out_tag | output | TAG_W | Slot index of the issued request |
| out_op | output | OP_W | Opcode of the issued request |
| out_payload | output | PLD_W | Payload of the issued request |
| out_allow_retry | output | 1 | Responder may answer this issue with a retry |
| rsp_valid | input | 1 | Response present |
| rsp_kind | input | 2 | 0 accept, 1 retry, 2 credit grant, 3 ignored |
| rsp_tag | input | TAG_W | Slot addressed by an accept or retry |
| rsp_busy | input | 1 | Responder is under heavy load |
| done_valid | output | 1 | A request completed |
| done_tag | output | TAG_W | Slot of the completed request |
| proto_err | output | 1 | Sticky flag: retry for a non-retryable issue |

## Verification
A lost or duplicated credit shows up at the ports within a few cycles. It appears either as a pending request that never issues after an accept or a grant, or as an issue beyond the credits the responder has handed out. A corrupted park queue shows up on the first grant, as a reissue of the wrong tag, out of order, or with allow-retry set. A wrong slot state shows up on the next response, as a missing or spurious completion, or as a payload that no longer matches the request the client handed in. The pacing counter is exposed by the spacing of new issues right after a busy response.

// File: rtl/crq_pkg.sv
package crq_pkg;

  typedef enum logic [1:0] {
    SLOT_FREE = 2'd0,
    SLOT_PEND = 2'd1,
    SLOT_SENT = 2'd2,
    SLOT_PARK = 2'd3
  } slot_st_e;

  localparam logic [1:0] RSP_ACCEPT = 2'd0;
  localparam logic [1:0] RSP_RETRY  = 2'd1;
  localparam logic [1:0] RSP_GRANT  = 2'd2;

endpackage

// File: rtl/crq_slot_bank.sv
module crq_slot_bank
  import crq_pkg::*;
#(
  parameter int SLOTS = 4,
  parameter int OP_W  = 4,
  parameter int PLD_W = 16,
  parameter int TAG_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_en,
  input  logic [TAG_W-1:0] alloc_idx,
  input  logic [OP_W-1:0]  alloc_op,
  input  logic [PLD_W-1:0] alloc_pld,
  input  logic             send_en,
  input  logic [TAG_W-1:0] send_idx,
  input  logic             send_ar,
  input  logic             park_en,
  input  logic [TAG_W-1:0] park_idx,
  input  logic             free_en,
  input  logic [TAG_W-1:0] free_idx,
  output slot_st_e         st_o  [SLOTS],
  output logic             ar_o  [SLOTS],
  output logic [OP_W-1:0]  op_o  [SLOTS],
  output logic [PLD_W-1:0] pld_o [SLOTS]
);

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    slot_st_e         st_q, st_d;
    logic             ar_q, ar_d;
    logic [OP_W-1:0]  op_q;
    logic [PLD_W-1:0] pld_q;
    logic             hit_alloc, hit_send, hit_park, hit_free;

    assign hit_alloc = alloc_en && (alloc_idx == TAG_W'(i));
    assign hit_send  = send_en  && (send_idx  == TAG_W'(i));
    assign hit_park  = park_en  && (park_idx  == TAG_W'(i));
    assign hit_free  = free_en  && (free_idx  == TAG_W'(i));

    always_comb begin
      st_d = st_q;
      ar_d = ar_q;
      if (hit_alloc) st_d = SLOT_PEND;
      if (hit_send) begin
        st_d = SLOT_SENT;
        ar_d = send_ar;
      end
      if (hit_park) st_d = SLOT_PARK;
      if (hit_free) st_d = SLOT_FREE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_q <= SLOT_FREE;
        ar_q <= 1'b0;
      end else begin
        st_q <= st_d;
        ar_q <= ar_d;
      end
    end

    always_ff @(posedge clk) begin
      if (hit_alloc) begin
        op_q  <= alloc_op;
        pld_q <= alloc_pld;
      end
    end

    assign st_o[i]  = st_q;
    assign ar_o[i]  = ar_q;
    assign op_o[i]  = op_q;
    assign pld_o[i] = pld_q;

    // R11
    alloc_into_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit_alloc |-> st_q == SLOT_FREE);

    // R12
    free_only_sent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit_free |-> st_q == SLOT_SENT);

    // R5
    park_only_sent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit_park |-> (st_q == SLOT_SENT && ar_q));
  end

endmodule

// File: rtl/crq_park_queue.sv
module crq_park_queue #(
  parameter int SLOTS = 4,
  parameter int TAG_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic [TAG_W-1:0] push_tag_i,
  input  logic             grant_i,
  input  logic             pop_i,
  output logic [TAG_W-1:0] head_o,
  output logic             ready_o,
  output logic             pool_o
);

  localparam int CNT_W = $clog2(SLOTS + 1);

  logic [TAG_W-1:0] mem [SLOTS];
  logic [TAG_W-1:0] rd_q, rd_d, wr_q, wr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, gcnt_q, gcnt_d;
  logic             bind_grant;

  function automatic logic [TAG_W-1:0] wrap_inc(input logic [TAG_W-1:0] p);
    return (p == TAG_W'(SLOTS - 1)) ? '0 : p + 1'b1;
  endfunction

  assign pool_o     = grant_i && (gcnt_q == cnt_q);
  assign bind_grant = grant_i && (gcnt_q != cnt_q);
  assign ready_o    = (gcnt_q != '0);
  assign head_o     = mem[rd_q];

  always_comb begin
    rd_d   = pop_i  ? wrap_inc(rd_q) : rd_q;
    wr_d   = push_i ? wrap_inc(wr_q) : wr_q;
    cnt_d  = cnt_q + CNT_W'(push_i) - CNT_W'(pop_i);
    gcnt_d = gcnt_q + CNT_W'(bind_grant) - CNT_W'(pop_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q   <= '0;
      wr_q   <= '0;
      cnt_q  <= '0;
      gcnt_q <= '0;
    end else begin
      rd_q   <= rd_d;
      wr_q   <= wr_d;
      cnt_q  <= cnt_d;
      gcnt_q <= gcnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_i) mem[wr_q] <= push_tag_i;
  end

  // R8
  grants_within_parked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gcnt_q <= cnt_q);

  // R5
  no_push_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |-> cnt_q < CNT_W'(SLOTS));

  // R6
  pop_needs_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i |-> gcnt_q != '0);

endmodule

// File: rtl/crq_pacer.sv
module crq_pacer #(
  parameter int GAP_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rsp_valid_i,
  input  logic             rsp_busy_i,
  input  logic             issue_i,
  input  logic [GAP_W-1:0] gap_cfg_i,
  output logic             open_o
);

  logic             busy_q, busy_d;
  logic [GAP_W-1:0] gap_q, gap_d;

  always_comb begin
    busy_d = rsp_valid_i ? rsp_busy_i : busy_q;
    if (issue_i)          gap_d = busy_q ? gap_cfg_i : '0;
    else if (gap_q != '0) gap_d = gap_q - 1'b1;
    else                  gap_d = gap_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      gap_q  <= '0;
    end else begin
      busy_q <= busy_d;
      gap_q  <= gap_d;
    end
  end

  assign open_o = (gap_q == '0);

  // R9
  gap_blocks_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gap_q != '0) |-> !issue_i);

endmodule

// File: rtl/crq_retry_ctrl.sv
module crq_retry_ctrl
  import crq_pkg::*;
#(
  parameter int              SLOTS        = 4,
  parameter int              OP_W         = 4,
  parameter int              PLD_W        = 16,
  parameter int              CRED_W       = 4,
  parameter int              INIT_CREDITS = 2,
  parameter int              GAP_W        = 4,
  parameter logic [OP_W-1:0] PREFETCH_OP  = '1,
  parameter int              TAG_W        = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [GAP_W-1:0] busy_gap,
  input  logic             in_valid,
  input  logic [OP_W-1:0]  in_op,
  input  logic [PLD_W-1:0] in_payload,
  output logic             in_ready,
  output logic             out_valid,
  output logic [TAG_W-1:0] out_tag,
  output logic [OP_W-1:0]  out_op,
  output logic [PLD_W-1:0] out_payload,
  output logic             out_allow_retry,
  input  logic             rsp_valid,
  input  logic [1:0]       rsp_kind,
  input  logic [TAG_W-1:0] rsp_tag,
  input  logic             rsp_busy,
  output logic             done_valid,
  output logic [TAG_W-1:0] done_tag,
  output logic             proto_err
);

  slot_st_e         bank_st  [SLOTS];
  logic             bank_ar  [SLOTS];
  logic [OP_W-1:0]  bank_op  [SLOTS];
  logic [PLD_W-1:0] bank_pld [SLOTS];

  logic             free_any, pend_any;
  logic [TAG_W-1:0] free_idx, pend_idx;
  logic             alloc_en;
  logic             pq_ready, pq_pool;
  logic [TAG_W-1:0] pq_head;
  logic             pace_open;
  logic             retry_go, new_go, send_en, send_ar;
  logic [TAG_W-1:0] send_idx;
  logic             rsp_in_range, rsp_hit, acc_hit, rty_hit, park_en, err_set, grant;
  logic [CRED_W-1:0] cred_q, cred_d;
  logic [CRED_W:0]   cred_sum;

  logic             out_valid_q, out_ar_q, done_valid_q, err_q;
  logic [TAG_W-1:0] out_tag_q, done_tag_q;
  logic [OP_W-1:0]  out_op_q;
  logic [PLD_W-1:0] out_pld_q;

  // lowest-index free and pending slots
  always_comb begin
    free_any = 1'b0;
    free_idx = '0;
    pend_any = 1'b0;
    pend_idx = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (bank_st[i] == SLOT_FREE) begin
        free_any = 1'b1;
        free_idx = TAG_W'(i);
      end
      if (bank_st[i] == SLOT_PEND) begin
        pend_any = 1'b1;
        pend_idx = TAG_W'(i);
      end
    end
  end

  assign in_ready = free_any;
  assign alloc_en = in_valid && free_any;

  // response decode
  always_comb begin
    rsp_in_range = (int'(rsp_tag) < SLOTS);
    rsp_hit      = rsp_valid && rsp_in_range && (bank_st[rsp_tag] == SLOT_SENT);
    acc_hit      = rsp_hit && (rsp_kind == RSP_ACCEPT);
    rty_hit      = rsp_hit && (rsp_kind == RSP_RETRY);
    park_en      = rty_hit && bank_ar[rsp_tag];
    err_set      = rty_hit && !bank_ar[rsp_tag];
    grant        = rsp_valid && (rsp_kind == RSP_GRANT);
  end

  // issue arbitration: granted reissues first, then new requests
  always_comb begin
    retry_go = pq_ready;
    new_go   = !pq_ready && pend_any && (cred_q != '0) && pace_open;
    send_en  = retry_go || new_go;
    send_idx = retry_go ? pq_head : pend_idx;
    send_ar  = retry_go ? 1'b0 : (bank_op[pend_idx] != PREFETCH_OP);
  end

  // credit pool
  always_comb begin
    cred_sum = {1'b0, cred_q} + (CRED_W + 1)'(acc_hit) + (CRED_W + 1)'(pq_pool)
             - (CRED_W + 1)'(new_go);
    cred_d   = cred_sum[CRED_W] ? '1 : cred_sum[CRED_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cred_q       <= CRED_W'(INIT_CREDITS);
      out_valid_q  <= 1'b0;
      done_valid_q <= 1'b0;
      err_q        <= 1'b0;
    end else begin
      cred_q       <= cred_d;
      out_valid_q  <= send_en;
      done_valid_q <= acc_hit;
      err_q        <= err_q || err_set;
    end
  end

  always_ff @(posedge clk) begin
    if (send_en) begin
      out_tag_q <= send_idx;
      out_op_q  <= bank_op[send_idx];
      out_pld_q <= bank_pld[send_idx];
      out_ar_q  <= send_ar;
    end
    if (acc_hit) done_tag_q <= rsp_tag;
  end

  crq_slot_bank #(
    .SLOTS(SLOTS), .OP_W(OP_W), .PLD_W(PLD_W), .TAG_W(TAG_W)
  ) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .alloc_en  (alloc_en),
    .alloc_idx (free_idx),
    .alloc_op  (in_op),
    .alloc_pld (in_payload),
    .send_en   (send_en),
    .send_idx  (send_idx),
    .send_ar   (send_ar),
    .park_en   (park_en),
    .park_idx  (rsp_tag),
    .free_en   (acc_hit),
    .free_idx  (rsp_tag),
    .st_o      (bank_st),
    .ar_o      (bank_ar),
    .op_o      (bank_op),
    .pld_o     (bank_pld)
  );

  crq_park_queue #(
    .SLOTS(SLOTS), .TAG_W(TAG_W)
  ) u_park (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_i     (park_en),
    .push_tag_i (rsp_tag),
    .grant_i    (grant),
    .pop_i      (retry_go),
    .head_o     (pq_head),
    .ready_o    (pq_ready),
    .pool_o     (pq_pool)
  );

  crq_pacer #(
    .GAP_W(GAP_W)
  ) u_pace (
    .clk         (clk),
    .rst_n       (rst_n),
    .rsp_valid_i (rsp_valid),
    .rsp_busy_i  (rsp_busy),
    .issue_i     (new_go),
    .gap_cfg_i   (busy_gap),
    .open_o      (pace_open)
  );

  assign out_valid       = out_valid_q;
  assign out_tag         = out_tag_q;
  assign out_op          = out_op_q;
  assign out_payload     = out_pld_q;
  assign out_allow_retry = out_ar_q;
  assign done_valid      = done_valid_q;
  assign done_tag        = done_tag_q;
  assign proto_err       = err_q;

  // R3
  prefetch_first_try_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_op == PREFETCH_OP) |-> !out_allow_retry);

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err);

  // R4
  accept_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_hit |=> (done_valid && done_tag == $past(rsp_tag)));

  // R6
  reissue_from_parked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    retry_go |-> bank_st[pq_head] == SLOT_PARK);

  // R2
  new_issue_has_credit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (send_en && send_ar) |-> cred_q != '0);

endmodule

// File: tb/crq_retry_ctrl_test.sv
`timescale 1ns/1ps
module crq_retry_ctrl_test;

  localparam int SLOTS = 4;
  localparam int OP_W  = 4;
  localparam int PLD_W = 16;
  localparam int TAG_W = 2;
  localparam int INITC = 2;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [3:0]       busy_gap;
  logic             in_valid;
  logic [OP_W-1:0]  in_op;
  logic [PLD_W-1:0] in_payload;
  logic             in_ready;
  logic             out_valid;
  logic [TAG_W-1:0] out_tag;
  logic [OP_W-1:0]  out_op;
  logic [PLD_W-1:0] out_payload;
  logic             out_allow_retry;
  logic             rsp_valid;
  logic [1:0]       rsp_kind;
  logic [TAG_W-1:0] rsp_tag;
  logic             rsp_busy;
  logic             done_valid;
  logic [TAG_W-1:0] done_tag;
  logic             proto_err;

  always #2 clk = ~clk;

  crq_retry_ctrl uut (
    .clk(clk), .rst_n(rst_n), .busy_gap(busy_gap),
    .in_valid(in_valid), .in_op(in_op), .in_payload(in_payload), .in_ready(in_ready),
    .out_valid(out_valid), .out_tag(out_tag), .out_op(out_op), .out_payload(out_payload),
    .out_allow_retry(out_allow_retry),
    .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_tag(rsp_tag), .rsp_busy(rsp_busy),
    .done_valid(done_valid), .done_tag(done_tag), .proto_err(proto_err)
  );

  int vecs = 0;
  int errs = 0;
  int cyc  = 0;
  bit finished = 0;

  // issue and completion logs filled by step()
  int o_tag[$];
  int o_ar[$];
  int o_op[$];
  int o_pld[$];
  int o_cyc[$];
  int d_tag[$];

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic clear_logs();
    o_tag.delete(); o_ar.delete(); o_op.delete(); o_pld.delete(); o_cyc.delete();
    d_tag.delete();
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    cyc++;
    if (out_valid) begin
      o_tag.push_back(int'(out_tag));
      o_ar.push_back(int'(out_allow_retry));
      o_op.push_back(int'(out_op));
      o_pld.push_back(int'(out_payload));
      o_cyc.push_back(cyc);
    end
    if (done_valid) d_tag.push_back(int'(done_tag));
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic reset_dut(input int gap);
    rst_n = 1'b0;
    busy_gap = 4'(gap);
    in_valid = 0; in_op = '0; in_payload = '0;
    rsp_valid = 0; rsp_kind = '0; rsp_tag = '0; rsp_busy = 0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    clear_logs();
  endtask

  task automatic push(input int op, input int pld);
    in_valid = 1; in_op = 4'(op); in_payload = 16'(pld);
    step();
    in_valid = 0;
  endtask

  task automatic respond(input int kind, input int tag, input bit busy);
    rsp_valid = 1; rsp_kind = 2'(kind); rsp_tag = 2'(tag); rsp_busy = busy;
    step();
    rsp_valid = 0; rsp_busy = 0;
  endtask

  function automatic int exp_ar(input int op);
    return (op == 15) ? 0 : 1;
  endfunction

  // ---------------- random phase state ----------------
  int pend_q[$];
  int park_q[$];
  bit outst[SLOTS];
  bit t_ar[SLOTS];
  int t_val[SLOTS];

  task automatic random_phase(input int ncyc, input int drain);
    int cred_m = INITC;
    int g = 0;
    int park_n = 0;
    int grant_n = 0;
    bit grant_prev = 0;
    bit exp_dn = 0;
    int exp_dt = 0;
    bit feeding;
    pend_q.delete(); park_q.delete();
    for (int s = 0; s < SLOTS; s++) outst[s] = 0;
    busy_gap = 4'd2;
    for (int c = 0; c < ncyc + drain; c++) begin
      feeding = (c < ncyc);
      step();
      // completions
      if (exp_dn) begin
        chk(d_tag.size() == 1 && d_tag[0] == exp_dt, "R4 random completion", d_tag.size() > 0 ? d_tag[0] : -1, exp_dt);
      end else begin
        chk(d_tag.size() == 0, "R12 random spurious completion", d_tag.size(), 0);
      end
      d_tag.delete();
      exp_dn = 0;
      // issues
      while (o_tag.size() > 0) begin
        int t = o_tag.pop_front();
        int a = o_ar.pop_front();
        int op = o_op.pop_front();
        int pl = o_pld.pop_front();
        void'(o_cyc.pop_front());
        if (g > 0) begin
          chk(t == park_q[0], "R8 reissue order", t, park_q[0]);
          chk(a == 0, "R6 reissue allow_retry", a, 0);
          chk(((op << 16) | pl) == t_val[t], "R3 reissue payload", (op << 16) | pl, t_val[t]);
          void'(park_q.pop_front());
          g--; park_n--; grant_n--;
        end else begin
          int hit = -1;
          foreach (pend_q[j]) if (hit < 0 && pend_q[j] == ((op << 16) | pl)) hit = j;
          chk(hit >= 0, "R3 issued request was handed in", (op << 16) | pl, 0);
          if (hit >= 0) pend_q.delete(hit);
          chk(a == exp_ar(op), "R3 first-issue allow_retry", a, exp_ar(op));
          chk(!outst[t], "R12 tag reused while outstanding", t, 0);
          cred_m--;
          chk(cred_m >= 0, "R2 issue without credit", cred_m, 0);
          t_val[t] = (op << 16) | pl;
        end
        outst[t] = 1;
        t_ar[t]  = a[0];
      end
      if (grant_prev) g++;
      grant_prev = 0;
      chk(proto_err == 0, "R10 no error on legal traffic", proto_err, 0);
      // drive new inputs
      in_valid = feeding && ($urandom % 2 == 0);
      in_op = 4'($urandom);
      in_payload = 16'($urandom);
      if (in_valid && in_ready) pend_q.push_back((int'(in_op) << 16) | int'(in_payload));
      rsp_valid = 0;
      rsp_busy = ($urandom % 3 == 0);
      if (park_n > grant_n && ($urandom % 4 == 0)) begin
        rsp_valid = 1; rsp_kind = 2'd2; rsp_tag = '0;
        grant_n++; grant_prev = 1;
      end else if ($urandom % 3 != 0) begin
        int st = $urandom % SLOTS;
        for (int k = 0; k < SLOTS; k++) begin
          int t = (st + k) % SLOTS;
          if (!rsp_valid && outst[t]) begin
            rsp_valid = 1; rsp_tag = 2'(t);
            outst[t] = 0;
            if (!t_ar[t] || ($urandom % 10 < 7)) begin
              rsp_kind = 2'd0; exp_dn = 1; exp_dt = t; cred_m++;
            end else begin
              rsp_kind = 2'd1; park_q.push_back(t); park_n++;
            end
          end
        end
      end
    end
    in_valid = 0; rsp_valid = 0;
    step();
    chk(pend_q.size() == 0 && park_q.size() == 0, "R4 all requests drained", pend_q.size() + park_q.size(), 0);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_c0de));

    // ---------- reset state, credits, payloads, completion ----------
    reset_dut(0);
    chk(in_ready == 1, "R1 in_ready after reset", in_ready, 1);
    chk(out_valid == 0, "R1 out_valid after reset", out_valid, 0);
    chk(done_valid == 0, "R1 done_valid after reset", done_valid, 0);
    chk(proto_err == 0, "R1 proto_err after reset", proto_err, 0);
    for (int i = 0; i < 4; i++) begin
      chk(in_ready == 1, "R11 ready while slots free", in_ready, 1);
      push(1, 'h100 + i);
    end
    chk(in_ready == 0, "R11 ready with all slots full", in_ready, 0);
    steps(4);
    chk(o_tag.size() == INITC, "R1 issues limited to initial credits", o_tag.size(), INITC);
    if (o_tag.size() == 2) begin
      chk(o_tag[0] == 0 && o_tag[1] == 1, "R3 issue tags", o_tag[1], 1);
      chk(o_pld[0] == 'h100 && o_pld[1] == 'h101, "R3 issue payloads", o_pld[1], 'h101);
      chk(o_ar[0] == 1 && o_ar[1] == 1, "R3 first issue retryable", o_ar[0], 1);
      chk(o_cyc[1] - o_cyc[0] == 1, "R9 back-to-back when not busy", o_cyc[1] - o_cyc[0], 1);
    end
    clear_logs();
    respond(0, 3, 0);
    step();
    chk(d_tag.size() == 0 && o_tag.size() == 0, "R12 accept for unsent slot ignored", d_tag.size(), 0);
    clear_logs();
    respond(0, 0, 0);
    chk(d_tag.size() == 1 && d_tag[0] == 0, "R4 done after accept", d_tag.size() > 0 ? d_tag[0] : -1, 0);
    chk(o_tag.size() == 0, "R2 no issue on accept edge", o_tag.size(), 0);
    step();
    chk(o_tag.size() == 1 && o_tag[0] == 2 && o_pld[0] == 'h102, "R2 returned credit issues next", o_tag.size() > 0 ? o_tag[0] : -1, 2);
    clear_logs();
    respond(1, 1, 0);
    steps(5);
    chk(o_tag.size() == 0, "R5 retry not reissued without grant", o_tag.size(), 0);
    chk(d_tag.size() == 0, "R5 retry gives no completion", d_tag.size(), 0);
    respond(2, 0, 0);
    chk(o_tag.size() == 0, "R6 reissue not on grant edge", o_tag.size(), 0);
    step();
    chk(o_tag.size() == 1 && o_tag[0] == 1, "R6 granted reissue tag", o_tag.size() > 0 ? o_tag[0] : -1, 1);
    if (o_tag.size() == 1) begin
      chk(o_ar[0] == 0, "R6 reissue allow_retry", o_ar[0], 0);
      chk(o_pld[0] == 'h101, "R3 reissue payload", o_pld[0], 'h101);
    end
    clear_logs();
    respond(1, 1, 0);
    chk(proto_err == 1, "R10 retry of non-retryable sets error", proto_err, 1);
    respond(0, 1, 0);
    chk(d_tag.size() == 1 && d_tag[0] == 1, "R10 request still completes", d_tag.size() > 0 ? d_tag[0] : -1, 1);
    step();
    chk(o_tag.size() == 1 && o_tag[0] == 3 && o_pld[0] == 'h103, "R2 credit from reissue accept", o_tag.size() > 0 ? o_tag[0] : -1, 3);
    chk(proto_err == 1, "R10 error is sticky", proto_err, 1);

    // ---------- prefetch-target opcode ----------
    reset_dut(0);
    push(15, 'h55);
    step();
    chk(o_tag.size() == 1 && o_ar[0] == 0, "R3 prefetch op not retryable", o_ar.size() > 0 ? o_ar[0] : -1, 0);
    push(3, 'h56);
    step();
    chk(o_tag.size() == 2 && o_ar[1] == 1, "R3 normal op retryable", o_ar.size() > 1 ? o_ar[1] : -1, 1);

    // ---------- grant with nothing parked ----------
    reset_dut(0);
    push(1, 'h10); push(1, 'h11); push(1, 'h12);
    steps(3);
    clear_logs();
    respond(2, 0, 0);
    step();
    chk(o_tag.size() == 1 && o_tag[0] == 2 && o_ar[0] == 1, "R7 idle grant adds pool credit", o_tag.size() > 0 ? o_tag[0] : -1, 2);

    // ---------- oldest-first service ----------
    reset_dut(0);
    push(1, 'h200); push(1, 'h201);
    steps(3);
    respond(1, 1, 0);
    respond(1, 0, 0);
    clear_logs();
    respond(2, 0, 0);
    respond(2, 0, 0);
    steps(2);
    chk(o_tag.size() == 2, "R8 both parked reissued", o_tag.size(), 2);
    if (o_tag.size() == 2) begin
      chk(o_tag[0] == 1 && o_tag[1] == 0, "R8 oldest parked first", o_tag[0], 1);
      chk(o_ar[0] == 0 && o_ar[1] == 0, "R6 reissues non-retryable", o_ar[1], 0);
    end

    // ---------- reissue ahead of new request ----------
    reset_dut(0);
    push(1, 'h300); push(1, 'h301);
    steps(3);
    respond(1, 0, 0);
    respond(0, 1, 0);
    clear_logs();
    in_valid = 1; in_op = 4'd1; in_payload = 16'h302;
    rsp_valid = 1; rsp_kind = 2'd2; rsp_tag = '0;
    step();
    in_valid = 0; rsp_valid = 0;
    steps(3);
    chk(o_tag.size() == 2, "R6 reissue and new both sent", o_tag.size(), 2);
    if (o_tag.size() == 2) begin
      chk(o_tag[0] == 0 && o_ar[0] == 0, "R6 reissue before new request", o_tag[0], 0);
      chk(o_tag[1] == 1 && o_pld[1] == 'h302 && o_ar[1] == 1, "R6 new request after reissue", o_pld[1], 'h302);
    end

    // ---------- busy pacing ----------
    reset_dut(3);
    push(1, 'h400);
    step();
    respond(0, 0, 1);
    clear_logs();
    push(1, 'h401); push(1, 'h402); push(1, 'h403);
    steps(8);
    chk(o_tag.size() == 2, "R9 two issues under busy", o_tag.size(), 2);
    if (o_tag.size() == 2)
      chk(o_cyc[1] - o_cyc[0] == 4, "R9 busy gap spacing", o_cyc[1] - o_cyc[0], 4);

    // ---------- constrained random ----------
    reset_dut(2);
    random_phase(3000, 400);

    summary();
    $finish;
  end

endmodule